// File: doc/BRIEF.md
# Sparse-Map Interrupt Level Controller

This block collects eight level-sensitive interrupt request lines and turns them into a sixteen-wire processor priority-level vector. Each request line has one fixed target level. The mapping is sparse and non-linear, and two of the lines have no target at all. The block also produces a 4-bit code naming the highest asserted level, so a processor that wants a single priority number does not need its own encoder.

Software controls the block through one byte-wide control register on a minimal byte port. A write strobe carries the write data, and the stored byte is always visible on the read data lines. Bit 0 of the register switches every output on or off. Bit 6 cannot be stored. The remaining bits are kept as plain state.

Requests do not latch. An output level is high only while a source mapped to it is high and the enable bit is set. Both outputs are registered and follow their inputs with one clock of delay.

Top module: `pil_irq_ctl`

## Requirements
- R1: While reset is asserted and after it is released, the control register reads 0x01, all sixteen level outputs are low and the encoded output is 0.
- R2: The read data port always shows the current contents of the control register. The stored byte appears there unchanged on the clock after a write.
- R3: On a write, the stored value is the write data ANDed with 0xBF, so bit 6 always reads back as 0. Every other bit keeps the value written.
- R4: Request inputs 1, 2, 3, 4, 5 and 7 drive level outputs 1, 4, 6, 8, 10 and 14 respectively. The output follows the input one clock later.
- R5: Request inputs 0 and 6 have no target level. Raising them, alone or together, changes neither the level vector nor the encoded output. Level output 0 never goes high.
- R6: Requests are level-sensitive and are not held. One clock after a request input falls, its level output is low.
- R7: Several active requests drive their own level outputs at the same time. The level vector is the OR of the contributions of all active sources.
- R8: When control bit 0 is 0, all sixteen level outputs and the encoded output are 0 for any request pattern.
- R9: The encoded output is the number of the highest asserted level output, or 0 when none is asserted.
- R10: A register write takes effect on the outputs one clock later. Setting bit 0 while requests are already high raises their levels on the next clock, with no new request edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 8 | Level-sensitive interrupt request lines, bit i is source i |
| cfg_we_i | input | 1 | Write strobe for the control register |
| cfg_wdata_i | input | 8 | Write data for the control register |
| cfg_rdata_o | output | 8 | Current control register contents |
| pil_o | output | 16 | Priority-level vector, bit n is level n |
| pil_top_o | output | 4 | Number of the highest asserted level, 0 if none |

## Verification
Several properties are checked on every cycle:
- the write mask on the control register;
- that level 0 is never driven;
- that the outputs are blank while the enable bit is clear;
- that each mapped level falls one clock after its source drops;
- that the encoded output always names the top set bit of the vector.

The exact sparse table can only be shown by the bench's scenarios. These drive all 256 request patterns with the enable on and again with it off, and compare each result with a reference model. The same holds for the reset value, for read-back of arbitrary bytes, and for re-enabling while requests are already high.

// File: rtl/pil_pkg.sv
package pil_pkg;

  localparam int unsigned SRC_N  = 8;
  localparam int unsigned LVL_N  = 16;
  localparam int unsigned LVL_W  = $clog2(LVL_N);
  localparam int unsigned CTRL_W = 8;

  localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'hBF;
  localparam logic [CTRL_W-1:0] CTRL_RSTV  = 8'h01;
  localparam int unsigned       CTRL_EN_BIT = 0;

  // fixed source-to-level table; level 0 means "no target"
  function automatic logic [LVL_W-1:0] src_level(input int unsigned idx);
    logic [LVL_W-1:0] lvl;
    case (idx)
      1:       lvl = LVL_W'(1);
      2:       lvl = LVL_W'(4);
      3:       lvl = LVL_W'(6);
      4:       lvl = LVL_W'(8);
      5:       lvl = LVL_W'(10);
      7:       lvl = LVL_W'(14);
      default: lvl = '0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/pil_rst_sync.sv
module pil_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n_o = sync_q[1];

endmodule

// File: rtl/pil_ctrl_reg.sv
module pil_ctrl_reg #(
  parameter int unsigned       W     = 8,
  parameter logic [W-1:0]      WMASK = 8'hBF,
  parameter logic [W-1:0]      RSTV  = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_d_o,
  output logic [W-1:0] ctrl_q_o
);

  logic [W-1:0] ctrl_d;
  logic [W-1:0] ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i) ctrl_d = wdata_i & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_q <= RSTV;
    else if (we_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_d_o = ctrl_d;
  assign ctrl_q_o = ctrl_q;

  // R3: stored byte is the written byte with the mask applied
  assert_wmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ctrl_q == ($past(wdata_i) & WMASK)));

endmodule

// File: rtl/pil_level_map.sv
module pil_level_map
  import pil_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned N_LVL = LVL_N
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic             en_i,
  output logic [N_LVL-1:0] lvl_o
);

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int unsigned s = 0; s < N_SRC; s++) begin
        if ((l != 0) && (int'(src_level(s)) == l)) hit = hit | req_i[s];
      end
    end
    assign lvl_o[l] = en_i & hit;
  end

endmodule

// File: rtl/pil_prio_enc.sv
module pil_prio_enc #(
  parameter int unsigned N = 16,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end

endmodule

// File: rtl/pil_irq_ctl.sv
module pil_irq_ctl
  import pil_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  req_i,
  input  logic              cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic [CTRL_W-1:0] cfg_rdata_o,
  output logic [LVL_N-1:0]  pil_o,
  output logic [LVL_W-1:0]  pil_top_o
);

  logic              srst_n;
  logic [CTRL_W-1:0] ctrl_d;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LVL_N-1:0]  pil_d;
  logic [LVL_N-1:0]  pil_q;
  logic [LVL_W-1:0]  top_d;
  logic [LVL_W-1:0]  top_q;
  logic              pil_chg;

  pil_rst_sync u_rst_sync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  pil_ctrl_reg #(
    .W     (CTRL_W),
    .WMASK (CTRL_WMASK),
    .RSTV  (CTRL_RSTV)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .ctrl_d_o (ctrl_d),
    .ctrl_q_o (ctrl_q)
  );

  pil_level_map #(
    .N_SRC (SRC_N),
    .N_LVL (LVL_N)
  ) u_map (
    .req_i (req_i),
    .en_i  (ctrl_d[CTRL_EN_BIT]),
    .lvl_o (pil_d)
  );

  pil_prio_enc #(
    .N (LVL_N),
    .W (LVL_W)
  ) u_enc (
    .vec_i (pil_d),
    .idx_o (top_d)
  );

  // clock enable: output flops load only when the computed vector moves
  assign pil_chg = (pil_d != pil_q);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pil_q <= '0;
      top_q <= '0;
    end else if (pil_chg) begin
      pil_q <= pil_d;
      top_q <= top_d;
    end
  end

  assign cfg_rdata_o = ctrl_q;
  assign pil_o       = pil_q;
  assign pil_top_o   = top_q;

  // R8: disabled controller shows no level
  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !ctrl_q[CTRL_EN_BIT] |-> (pil_q == '0) && (top_q == '0));

  // R5: level 0 is never driven
  assert_no_lvl0_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !pil_q[0]);

  // R9: encoded output is zero exactly when the vector is empty
  assert_top_zero_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (pil_q == '0) == (top_q == '0));

  // R9: encoded output names the top set bit
  assert_top_bit_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (pil_q != '0) |-> ((pil_q >> top_q) == LVL_N'(1)));

  // R6: a dropped request clears its level on the next clock
  for (genvar s = 0; s < SRC_N; s++) begin : g_chk
    if (src_level(s) != '0) begin : g_mapped
      assert_drop_R6: assert property (@(posedge clk) disable iff (!srst_n)
        !req_i[s] |=> !pil_q[src_level(s)]);
    end
  end

endmodule

// File: tb/pil_irq_ctl_tb.sv
module pil_irq_ctl_tb;

  typedef struct {
    logic [15:0] pil;
    logic [3:0]  top;
    logic [7:0]  rd;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [7:0]  req;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [15:0] pil;
  logic [3:0]  pil_top;

  int   n_chk;
  int   n_fail;
  bit   drv_done;
  exp_t sb_q[$];
  logic [7:0] m_ctrl;
  int   tbl [8] = '{0, 1, 4, 6, 8, 10, 0, 14};

  pil_irq_ctl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .pil_o       (pil),
    .pil_top_o   (pil_top)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] r, input logic we,
                      input logic [7:0] wd, input string tag);
    exp_t e;
    logic [15:0] p;
    logic [3:0]  t;
    @(negedge clk);
    req = r; cfg_we = we; cfg_wdata = wd;
    if (we) m_ctrl = wd & 8'hBF;
    p = '0;
    if (m_ctrl[0]) begin
      for (int i = 0; i < 8; i++) if (tbl[i] != 0 && r[i]) p[tbl[i]] = 1'b1;
    end
    t = '0;
    for (int i = 0; i < 16; i++) if (p[i]) t = 4'(i);
    e.pil = p; e.top = t; e.rd = m_ctrl; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each capturing edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(pil == e.pil, e.tag, "pil", 32'(pil), 32'(e.pil));
        chk(pil_top == e.top, e.tag, "top", 32'(pil_top), 32'(e.top));
        chk(cfg_rdata == e.rd, e.tag, "rdata", 32'(cfg_rdata), 32'(e.rd));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    string tg;
    logic [7:0] live;
    n_chk = 0; n_fail = 0; drv_done = 0;
    m_ctrl = 8'h01;
    rst_n = 1'b0; req = '0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cfg_rdata == 8'h01, "R1", "rdata", 32'(cfg_rdata), 32'h01);
    chk(pil == '0, "R1", "pil", 32'(pil), 32'h0);
    chk(pil_top == '0, "R1", "top", 32'(pil_top), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cfg_rdata == 8'h01, "R1", "rdata after release", 32'(cfg_rdata), 32'h01);

    // enabled: every request pattern
    for (int r = 0; r < 256; r++) begin
      live = 8'(r) & 8'hBE;
      if (r == 0)                    tg = "R9";
      else if (live == 0)            tg = "R5";
      else if ($countones(live) == 1) tg = "R4";
      else                           tg = "R7/R9";
      step(8'(r), 1'b0, 8'h00, tg);
    end
    // R6: request drop
    step(8'h80, 1'b0, 8'h00, "R6");
    step(8'h00, 1'b0, 8'h00, "R6");
    step(8'h24, 1'b0, 8'h00, "R6");
    step(8'h04, 1'b0, 8'h00, "R6");
    // R3: write mask
    step(8'h00, 1'b1, 8'hFF, "R3");
    step(8'h00, 1'b1, 8'h40, "R3");
    // R8: disabled, every pattern
    for (int r = 0; r < 256; r++) step(8'(r), 1'b0, 8'h00, "R8");
    // R10: enable with requests already high
    step(8'hFE, 1'b0, 8'h00, "R10");
    step(8'hFE, 1'b1, 8'h01, "R10");
    step(8'hFE, 1'b1, 8'h00, "R10");
    // R2: read-back of arbitrary bytes
    step(8'h22, 1'b1, 8'h5A, "R2");
    step(8'h22, 1'b1, 8'h81, "R2");
    step(8'h22, 1'b1, 8'hA5, "R2");
    step(8'h22, 1'b0, 8'h00, "R2");
    drv_done = 1;
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule